// File: doc/BRIEF.md
# Three-Line GPIO with Power-Button Press Detect

This block gives a host three bidirectional general-purpose lines and one power-button input, all reached through byte-wide registers on a single select/write/read port. Each line has a direction bit and an output latch bit. A direction bit of 0 makes the line an output: the block raises the pad drive enable and drives the latched value. A direction bit of 1 makes the line an input, and its pad level is sampled.

Every pad input passes through a two-flop synchronizer. The synchronized line levels form the input readback. On that readback, lines in output mode also show their latched output value. The power-button input never appears as a general line. A low-to-high transition on it produces a one-cycle press strobe meant for an external interrupt controller. Level changes on the three general lines never produce a strobe.

Top module: `gpio_pb_top`

## Requirements
- R1: While reset is asserted and after it is released, the direction register reads 0x07, the output latch reads 0x00, all drive enables are 0 and press_o is 0.
- R2: A write with reg_sel_i = 0 (direction) stores wr_data_i AND 0x67. The stored value is visible on rd_data_o with reg_sel_i = 0 after the write edge.
- R3: A write with reg_sel_i = 2 (output latch) stores wr_data_i AND 0x07. The stored value is visible on rd_data_o with reg_sel_i = 2 after the write edge.
- R4: For each line n, line_oe_o[n] is the inverse of direction bit n. line_o[n] is output latch bit n AND NOT direction bit n.
- R5: With reg_sel_i = 1 (input readback), rd_data_o equals the synchronized line levels in bits 2:0, ORed with (NOT direction AND output latch). A pad change shows up after the second rising clock edge.
- R6: Writes with reg_sel_i = 1 or 3 change neither register nor any line output. Reading with reg_sel_i = 3 returns 0x00.
- R7: A low-to-high transition on pwr_btn_i makes press_o high for exactly one cycle. The strobe rises after the second rising clock edge that follows the transition.
- R8: A button held high raises no further strobe. Level changes on line_i never raise press_o.
- R9: A button already high when reset is released produces exactly one strobe, on the second synchronized sample after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 2 | Register select: 0 direction, 1 input readback, 2 output latch, 3 unused |
| wr_en_i | input | 1 | Write strobe for the selected register |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data of the selected register |
| line_i | input | 3 | Pad levels of the general lines |
| line_o | output | 3 | Drive values of the general lines |
| line_oe_o | output | 3 | Pad drive enables, 1 = drive |
| pwr_btn_i | input | 1 | Power-button level |
| press_o | output | 1 | One-cycle press strobe |

## Verification
The bench targets the write masks with all-ones and mixed patterns. A design that stored the raw byte would read back bits the masks must clear, or would change pad enables. It checks the input readback in mixed direction settings and at the exact synchronizer latency. A wrong merge would hide latched outputs or leak them onto input lines, and a missing or extra stage would show up one cycle off. On the button it counts strobes over long held-high intervals, after a second press, and with the button held across reset. A level detector instead of an edge detector would repeat the strobe, and a design that treats the general lines as interrupt sources would strobe on line toggles.

// File: rtl/gpio_pb_pkg.sv
package gpio_pb_pkg;
  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_IN   = 2'd1,
    SEL_OUT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pb_pkg::*;
#(
  parameter int                NUM_LINES = 3,
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] DIR_MASK  = 8'h67,
  parameter logic [DATA_W-1:0] DIR_RST   = 8'h07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] dir_q_o,
  output logic [DATA_W-1:0] out_q_o
);
  localparam logic [DATA_W-1:0] OUT_MASK = DATA_W'((1 << NUM_LINES) - 1);

  logic [DATA_W-1:0] dir_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= DIR_RST;
      out_q <= '0;
    end else if (wr_en_i) begin
      if (sel_i == SEL_DIR) dir_q <= wr_data_i & DIR_MASK;
      if (sel_i == SEL_OUT) out_q <= wr_data_i & OUT_MASK;
    end
  end

  assign dir_q_o = dir_q;
  assign out_q_o = out_q;
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic prev_q;

  // prev resets low: a level already high yields one strobe
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= d_i;

  assign rise_o = d_i & ~prev_q;
endmodule

// File: rtl/gpio_pb_top.sv
module gpio_pb_top
  import gpio_pb_pkg::*;
#(
  parameter int                NUM_LINES   = 3,
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] DIR_MASK    = 8'h67,
  parameter logic [DATA_W-1:0] DIR_RST     = 8'h07
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           reg_sel_i,
  input  logic                 wr_en_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic [DATA_W-1:0]    rd_data_o,
  input  logic [NUM_LINES-1:0] line_i,
  output logic [NUM_LINES-1:0] line_o,
  output logic [NUM_LINES-1:0] line_oe_o,
  input  logic                 pwr_btn_i,
  output logic                 press_o
);
  localparam int SYNC_W = NUM_LINES + 1;

  reg_sel_e             sel;
  logic [DATA_W-1:0]    dir_q, out_q;
  logic [SYNC_W-1:0]    sync_q;
  logic [NUM_LINES-1:0] line_s;
  logic                 btn_s;
  logic [DATA_W-1:0]    in_rb;

  assign sel = reg_sel_e'(reg_sel_i);

  gpio_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({pwr_btn_i, line_i}),
    .q_o    (sync_q)
  );

  assign line_s = sync_q[NUM_LINES-1:0];
  assign btn_s  = sync_q[NUM_LINES];

  gpio_regs #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .DIR_MASK  (DIR_MASK),
    .DIR_RST   (DIR_RST)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .sel_i     (sel),
    .wr_data_i (wr_data_i),
    .dir_q_o   (dir_q),
    .out_q_o   (out_q)
  );

  gpio_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (btn_s),
    .rise_o (press_o)
  );

  assign line_oe_o = ~dir_q[NUM_LINES-1:0];
  assign line_o    = out_q[NUM_LINES-1:0] & ~dir_q[NUM_LINES-1:0];

  // output-mode lines show their latch on readback
  assign in_rb = {{(DATA_W-NUM_LINES){1'b0}}, line_s} | (~dir_q & out_q);

  always_comb begin
    unique case (sel)
      SEL_DIR:  rd_data_o = dir_q;
      SEL_IN:   rd_data_o = in_rb;
      SEL_OUT:  rd_data_o = out_q;
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pb_chk.sv
module gpio_pb_chk #(
  parameter int                NUM_LINES = 3,
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] DIR_MASK  = 8'h67
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [1:0]           reg_sel_i,
  input logic                 wr_en_i,
  input logic [DATA_W-1:0]    wr_data_i,
  input logic [DATA_W-1:0]    rd_data_o,
  input logic [NUM_LINES-1:0] line_oe_o,
  input logic                 press_o,
  input logic                 btn_s,
  input logic [DATA_W-1:0]    dir_q,
  input logic [DATA_W-1:0]    out_q
);
  localparam logic [DATA_W-1:0] OUT_MASK = DATA_W'((1 << NUM_LINES) - 1);

  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reg_sel_i == 2'd0) |=> dir_q == ($past(wr_data_i) & DIR_MASK));

  p_out_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reg_sel_i == 2'd2) |=> out_q == ($past(wr_data_i) & OUT_MASK));

  p_oe_vs_dir_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i == 2'd0) |-> rd_data_o[NUM_LINES-1:0] == ~line_oe_o);

  p_rb_merge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i == 2'd1) |-> (rd_data_o & out_q & ~dir_q) == (out_q & ~dir_q));

  p_ro_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reg_sel_i[0]) |=> $stable(dir_q) && $stable(out_q));

  p_press_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_o |=> !press_o);

  p_press_needs_btn_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !btn_s |-> !press_o);
endmodule

bind gpio_pb_top gpio_pb_chk #(
  .NUM_LINES (NUM_LINES),
  .DATA_W    (DATA_W),
  .DIR_MASK  (DIR_MASK)
) i_chk (.*);

// File: tb/test_gpio_pb_top.sv
module test_gpio_pb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [2:0] line_in = 3'b000;
  logic [2:0] line_out, line_oe;
  logic       pwr_btn = 1'b0;
  logic       press;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_pb_top i_gpio_pb_top (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .reg_sel_i (reg_sel),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .line_i    (line_in),
    .line_o    (line_out),
    .line_oe_o (line_oe),
    .pwr_btn_i (pwr_btn),
    .press_o   (press)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    reg_sel = sel; #1; d = rd_data;
  endtask

  task automatic t_reset_and_held_button;
    logic [7:0] v;
    int pulses;
    pwr_btn = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R1 dir in reset", v, 8'h07);
    rd(2'd2, v); chk("R1 out in reset", v, 8'h00);
    chk("R1 oe in reset", {5'd0, line_oe}, 8'h00);
    chk("R1 press in reset", {7'd0, press}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    cyc(1); chk("R9 no press after first edge", {7'd0, press}, 8'h00);
    cyc(1); chk("R9 press on second sample", {7'd0, press}, 8'h01);
    pulses = 0;
    repeat (10) begin cyc(1); if (press) pulses++; end
    chk("R9 single strobe while held", 8'(pulses), 8'd0);
    rd(2'd0, v); chk("R1 dir after reset", v, 8'h07);
    pwr_btn = 1'b0; cyc(4);
  endtask

  task automatic t_dir_write;
    logic [7:0] v;
    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 dir 0xFF", v, 8'h67);
    chk("R4 oe all inputs", {5'd0, line_oe}, 8'h00);
    wr(2'd0, 8'h00); rd(2'd0, v); chk("R2 dir 0x00", v, 8'h00);
    chk("R4 oe all outputs", {5'd0, line_oe}, 8'h07);
    wr(2'd0, 8'h9A); rd(2'd0, v); chk("R2 dir 0x9A", v, 8'h02);
    chk("R4 oe mixed", {5'd0, line_oe}, 8'h05);
  endtask

  task automatic t_out_write;
    logic [7:0] v;
    wr(2'd0, 8'h02);
    wr(2'd2, 8'hFD); rd(2'd2, v); chk("R3 out 0xFD", v, 8'h05);
    chk("R4 drive 101", {5'd0, line_out}, 8'h05);
    wr(2'd2, 8'hFA); rd(2'd2, v); chk("R3 out 0xFA", v, 8'h02);
    chk("R4 input line not driven", {5'd0, line_out}, 8'h00);
  endtask

  task automatic t_readback;
    logic [7:0] v;
    wr(2'd0, 8'h07); wr(2'd2, 8'h05);
    line_in = 3'b010; cyc(2);
    rd(2'd1, v); chk("R5 all inputs", v, 8'h02);
    wr(2'd0, 8'h06);
    rd(2'd1, v); chk("R5 merge output line0", v, 8'h03);
    line_in = 3'b000; cyc(2);
    rd(2'd1, v); chk("R5 latch only", v, 8'h01);
    line_in = 3'b100; cyc(1);
    rd(2'd1, v); chk("R5 one edge too early", v, 8'h01);
    cyc(1);
    rd(2'd1, v); chk("R5 after two edges", v, 8'h05);
  endtask

  task automatic t_ignored;
    logic [7:0] v;
    wr(2'd1, 8'hFF); wr(2'd3, 8'h00);
    rd(2'd0, v); chk("R6 dir unchanged", v, 8'h06);
    rd(2'd2, v); chk("R6 out unchanged", v, 8'h05);
    chk("R6 drive unchanged", {5'd0, line_out}, 8'h01);
    rd(2'd3, v); chk("R6 unused reads 0", v, 8'h00);
  endtask

  task automatic t_lines_no_press;
    int pulses = 0;
    for (int i = 0; i < 16; i++) begin
      line_in = 3'(i); cyc(1);
      if (press) pulses++;
    end
    cyc(3); if (press) pulses++;
    chk("R8 lines raise no press", 8'(pulses), 8'd0);
  endtask

  task automatic t_press;
    int pulses;
    pwr_btn = 1'b1;
    cyc(1); chk("R7 no press after one edge", {7'd0, press}, 8'h00);
    cyc(1); chk("R7 press after two edges", {7'd0, press}, 8'h01);
    cyc(1); chk("R7 strobe lasts one cycle", {7'd0, press}, 8'h00);
    pulses = 0;
    repeat (12) begin cyc(1); if (press) pulses++; end
    chk("R8 held high no repeat", 8'(pulses), 8'd0);
    pwr_btn = 1'b0; cyc(4);
    chk("R8 no press on release", {7'd0, press}, 8'h00);
    pwr_btn = 1'b1; pulses = 0;
    repeat (8) begin cyc(1); if (press) pulses++; end
    chk("R7 second press one strobe", 8'(pulses), 8'd1);
    pwr_btn = 1'b0; cyc(3);
  endtask

  initial begin
    t_reset_and_held_button();
    t_dir_write();
    t_out_write();
    t_readback();
    t_ignored();
    t_lines_no_press();
    t_press();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; fails++;
          $display("FAIL watchdog expired");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule